// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 8-bit CPU that takes an interrupt and comes back from one. It watches a vector of pending requests. At the last cycle of a main-program instruction it decides whether to start an entry. An entry saves the two-byte return address on a byte-wide stack in memory, moves the stack pointer down by two and loads the program counter with the vector of the chosen request. A return-from-interrupt instruction runs the same steps the other way. It reads the two bytes back, moves the stack pointer up by two and reloads the program counter.

Instruction decode is not part of the block. The CPU tells the sequencer when an instruction is in its final cycle, whether that instruction is a return, and which address execution would continue from. While a sequence runs, the block raises a busy output so that fetch stalls. It also owns the global interrupt enable: the enable is cleared on entry and set again by the return. Before a pending request can be taken after a return, one main-program instruction must finish. The jump found at the vector is a separate three-cycle step and is left to the fetch logic.

Top module: `intr_seq`

## Requirements
- R1: While reset is low, and in the cycle after it is released, busy, the stack write and read strobes, the program counter load and every acknowledge bit are 0. The stack pointer holds its initial value (0x00F0 by default) and the interrupt enable is 1.
- R2: An entry is accepted only when all of these hold together at a rising edge: the block is idle, `insn_last_i` is 1, `insn_reti_i` is 0, the enable is 1 and at least one request bit is 1. A multi-cycle instruction therefore finishes before entry, and no entry starts while the enable is 0.
- R3: Call the acceptance edge cycle 0. In cycle 1 the block writes the low byte of the captured return address at the stack pointer. In cycle 2 it writes the high byte, zero-padded above the counter width, at the stack pointer minus 1. From cycle 3 on, the stack pointer is 2 lower, and it only ever changes by one per cycle.
- R4: In cycle 4 of an entry, the program counter load pulses with vector = base (2 by default) + 2 × index. The index is the lowest-numbered request pending at cycle 0. Later changes of the request inputs do not affect it. In the same cycle the acknowledge output is one-hot on that index. At all other times it is 0.
- R5: The interrupt enable is 0 from cycle 1 of an entry until the return restores it.
- R6: When `insn_last_i` and `insn_reti_i` are both 1 at an idle edge, a return starts, even if requests are pending. In cycle 1 it reads at stack pointer + 1, which holds the high byte. In cycle 2 it reads at stack pointer + 2, which holds the low byte. The stack data input is used in the same cycle as the read strobe. In cycle 4 the program counter load carries {high, low}. The stack pointer ends 2 higher and the enable is 1 from cycle 5.
- R7: Busy is 1 in exactly cycles 1 to 4 of either sequence. `insn_last_i` and `insn_reti_i` have no effect while busy. No strobe or load appears while the block is idle.
- R8: After a return, no entry begins before a main-program instruction has signalled its last cycle. The earliest entry follows that instruction's last cycle.
- R9: The stack write strobe, the stack read strobe and the program counter load are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Pending request levels, bit 0 has the highest priority |
| insn_last_i | input | 1 | Current instruction is in its final cycle |
| insn_reti_i | input | 1 | The finishing instruction is a return-from-interrupt |
| pc_next_i | input | PC_W | Address execution continues from after the finishing instruction |
| stk_rdata_i | input | 8 | Stack byte at `stk_addr_o`, valid in the same cycle |
| busy_o | output | 1 | Entry or return in progress; fetch must stall |
| pc_load_o | output | 1 | Load the program counter with `pc_load_val_o` |
| pc_load_val_o | output | PC_W | Vector address or restored return address |
| stk_we_o | output | 1 | Stack byte write strobe |
| stk_re_o | output | 1 | Stack byte read strobe |
| stk_addr_o | output | SP_W | Stack memory byte address |
| stk_wdata_o | output | 8 | Stack byte to be written |
| sp_o | output | SP_W | Current stack pointer |
| gie_o | output | 1 | Global interrupt enable |
| ack_o | output | NUM_REQ | One-hot acknowledge of the request being serviced |

## Verification
Two pairs of events can fall in the same cycle. The first is a return reaching its last cycle while requests are pending. The second is the first instruction after a return finishing while requests are still pending. The bench provokes both: it holds several request bits high across a return instruction and across the instruction that follows it. It then judges three things. The return must run to completion before any entry. Busy must stay low through the whole next instruction. The vector must match the lowest pending index. Randomly raised instruction-end pulses and new request bits are also injected inside running sequences. Each must leave the stack traffic, vector and stack pointer exactly as the acceptance cycle determined.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      S_IDLE     = 4'd0,
      S_PUSH_LO  = 4'd1,
      S_PUSH_HI  = 4'd2,
      S_PUSH_GAP = 4'd3,
      S_VEC_LD   = 4'd4,
      S_POP_HI   = 4'd5,
      S_POP_LO   = 4'd6,
      S_POP_GAP  = 4'd7,
      S_RET_LD   = 4'd8
   } seq_state_e;

   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int NUM_REQ = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_REQ-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);

   generate
      if (NUM_REQ == 1) begin : g_single
         assign any_o = req_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         // scan from the top so the lowest set bit is the last to write
         always_comb begin
            idx_o = '0;
            for (int i = NUM_REQ - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
         assign any_o = |req_i;
      end
   endgenerate

endmodule

// File: rtl/intr_stack_ptr.sv
module intr_stack_ptr #(
   parameter int SP_W    = 16,
   parameter int SP_INIT = 'hF0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_i,
   input  logic            inc_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] sp_inc_o
);

   logic [SP_W-1:0] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_W'(SP_INIT);
      end else if (dec_i) begin
         sp_q <= sp_q - SP_W'(1);
      end else if (inc_i) begin
         sp_q <= sp_q + SP_W'(1);
      end
   end

   assign sp_o     = sp_q;
   assign sp_inc_o = sp_q + SP_W'(1);

endmodule

// File: rtl/intr_seq_ctl.sv
module intr_seq_ctl
   import intr_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic insn_last_i,
   input  logic insn_reti_i,
   input  logic gie_i,
   input  logic any_req_i,
   output logic accept_o,
   output logic push_lo_o,
   output logic push_hi_o,
   output logic pop_hi_o,
   output logic pop_lo_o,
   output logic vec_ld_o,
   output logic ret_ld_o,
   output logic busy_o
);

   seq_state_e st_q, st_d;
   logic       idle, ret_start;

   assign idle      = (st_q == S_IDLE);
   assign ret_start = idle && insn_last_i && insn_reti_i;
   assign accept_o  = idle && insn_last_i && !insn_reti_i && gie_i && any_req_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE: begin
            if (ret_start)     st_d = S_POP_HI;
            else if (accept_o) st_d = S_PUSH_LO;
         end
         S_PUSH_LO:  st_d = S_PUSH_HI;
         S_PUSH_HI:  st_d = S_PUSH_GAP;
         S_PUSH_GAP: st_d = S_VEC_LD;
         S_VEC_LD:   st_d = S_IDLE;
         S_POP_HI:   st_d = S_POP_LO;
         S_POP_LO:   st_d = S_POP_GAP;
         S_POP_GAP:  st_d = S_RET_LD;
         S_RET_LD:   st_d = S_IDLE;
         default:    st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   assign push_lo_o = (st_q == S_PUSH_LO);
   assign push_hi_o = (st_q == S_PUSH_HI);
   assign pop_hi_o  = (st_q == S_POP_HI);
   assign pop_lo_o  = (st_q == S_POP_LO);
   assign vec_ld_o  = (st_q == S_VEC_LD);
   assign ret_ld_o  = (st_q == S_RET_LD);
   assign busy_o    = !idle;

endmodule

// File: rtl/intr_seq.sv
module intr_seq
   import intr_seq_pkg::*;
#(
   parameter int NUM_REQ  = 8,
   parameter int PC_W     = 14,
   parameter int SP_W     = 16,
   parameter int VEC_BASE = 2,
   parameter int SP_INIT  = 'hF0,
   parameter bit GIE_INIT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               insn_last_i,
   input  logic               insn_reti_i,
   input  logic [PC_W-1:0]    pc_next_i,
   input  logic [7:0]         stk_rdata_i,
   output logic               busy_o,
   output logic               pc_load_o,
   output logic [PC_W-1:0]    pc_load_val_o,
   output logic               stk_we_o,
   output logic               stk_re_o,
   output logic [SP_W-1:0]    stk_addr_o,
   output logic [7:0]         stk_wdata_o,
   output logic [SP_W-1:0]    sp_o,
   output logic               gie_o,
   output logic [NUM_REQ-1:0] ack_o
);

   localparam int IDX_W   = idx_width(NUM_REQ);
   localparam int WORD_W  = 2 * BYTE_W;
   localparam int TOP_VEC = VEC_BASE + 2 * (NUM_REQ - 1);

   // elaboration-time parameter checks
   generate
      if (PC_W <= BYTE_W || PC_W > WORD_W) begin : g_bad_pc_w
         $error("intr_seq: PC_W must lie in 9..16");
      end
      if (SP_W < BYTE_W || SP_W > WORD_W) begin : g_bad_sp_w
         $error("intr_seq: SP_W must lie in 8..16");
      end
      if (NUM_REQ < 1 || NUM_REQ > 32) begin : g_bad_num
         $error("intr_seq: NUM_REQ must lie in 1..32");
      end
      if (VEC_BASE < 0 || TOP_VEC >= (1 << PC_W)) begin : g_bad_vec
         $error("intr_seq: vector table exceeds the address space");
      end
      if (SP_INIT < 0 || SP_INIT >= (1 << SP_W)) begin : g_bad_sp_init
         $error("intr_seq: SP_INIT does not fit SP_W");
      end
   endgenerate

   logic             any_req;
   logic [IDX_W-1:0] pick_idx;
   logic             accept;
   logic             push_lo, push_hi, pop_hi, pop_lo, vec_ld, ret_ld, busy;
   logic [SP_W-1:0]  sp, sp_inc;

   intr_prio_pick #(
      .NUM_REQ(NUM_REQ),
      .IDX_W  (IDX_W)
   ) u_pick (
      .req_i(req_i),
      .any_o(any_req),
      .idx_o(pick_idx)
   );

   logic gie_q;

   intr_seq_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_last_i(insn_last_i),
      .insn_reti_i(insn_reti_i),
      .gie_i      (gie_q),
      .any_req_i  (any_req),
      .accept_o   (accept),
      .push_lo_o  (push_lo),
      .push_hi_o  (push_hi),
      .pop_hi_o   (pop_hi),
      .pop_lo_o   (pop_lo),
      .vec_ld_o   (vec_ld),
      .ret_ld_o   (ret_ld),
      .busy_o     (busy)
   );

   intr_stack_ptr #(
      .SP_W   (SP_W),
      .SP_INIT(SP_INIT)
   ) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_i   (push_lo | push_hi),
      .inc_i   (pop_hi | pop_lo),
      .sp_o    (sp),
      .sp_inc_o(sp_inc)
   );

   // return address widened to two bytes, with the restored word narrowed back
   logic [WORD_W-1:0] pc_wide;
   logic [WORD_W-1:0] ret_word;
   logic [PC_W-1:0]   ret_pc;
   logic [7:0]        ret_hi_q, ret_lo_q;

   assign ret_word = {ret_hi_q, ret_lo_q};

   generate
      if (PC_W == WORD_W) begin : g_full_pc
         assign pc_wide = pc_next_i;
         assign ret_pc  = ret_word;
      end else begin : g_pad_pc
         logic unused_ret_hi;
         assign pc_wide       = {{(WORD_W - PC_W){1'b0}}, pc_next_i};
         assign ret_pc        = ret_word[PC_W-1:0];
         assign unused_ret_hi = ^ret_word[WORD_W-1:PC_W];
      end
   endgenerate

   logic [WORD_W-1:0] pc_cap_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_cap_q <= '0;
         idx_q    <= '0;
      end else if (accept) begin
         pc_cap_q <= pc_wide;
         idx_q    <= pick_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_hi_q <= '0;
         ret_lo_q <= '0;
      end else begin
         if (pop_hi) ret_hi_q <= stk_rdata_i;
         if (pop_lo) ret_lo_q <= stk_rdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= GIE_INIT;
      end else if (accept) begin
         gie_q <= 1'b0;
      end else if (ret_ld) begin
         gie_q <= 1'b1;
      end
   end

   logic [PC_W-1:0] vec_addr;
   assign vec_addr = PC_W'(VEC_BASE) + (PC_W'(idx_q) << 1);

   assign busy_o        = busy;
   assign pc_load_o     = vec_ld | ret_ld;
   assign pc_load_val_o = vec_ld ? vec_addr : (ret_ld ? ret_pc : '0);
   assign stk_we_o      = push_lo | push_hi;
   assign stk_re_o      = pop_hi | pop_lo;
   assign stk_addr_o    = (pop_hi | pop_lo) ? sp_inc : sp;
   assign stk_wdata_o   = push_hi ? pc_cap_q[WORD_W-1:BYTE_W]
                        : (push_lo ? pc_cap_q[BYTE_W-1:0] : 8'h00);
   assign sp_o          = sp;
   assign gie_o         = gie_q;
   assign ack_o         = vec_ld ? (NUM_REQ'(1) << idx_q) : '0;

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
   parameter int NUM_REQ = 8,
   parameter int SP_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] req_i,
   input logic               insn_last_i,
   input logic               insn_reti_i,
   input logic               busy_o,
   input logic               pc_load_o,
   input logic               stk_we_o,
   input logic               stk_re_o,
   input logic [SP_W-1:0]    stk_addr_o,
   input logic [SP_W-1:0]    sp_o,
   input logic               gie_o,
   input logic [NUM_REQ-1:0] ack_o
);

   // set when the enable comes back after a return, cleared by the next instruction end
   logic gie_d_q, wait_insn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_d_q     <= 1'b1;
         wait_insn_q <= 1'b0;
      end else begin
         gie_d_q <= gie_o;
         if (insn_last_i && !busy_o)  wait_insn_q <= 1'b0;
         else if (gie_o && !gie_d_q)  wait_insn_q <= 1'b1;
      end
   end

   AST_ENTRY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && insn_last_i && !insn_reti_i && gie_o && (|req_i)) |=> (busy_o && stk_we_o && !gie_o)); // R2

   AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && !$past(stk_we_o)) |=> (stk_we_o && stk_addr_o == $past(stk_addr_o) - SP_W'(1))); // R3

   AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sp_o) |-> (sp_o == $past(sp_o) + SP_W'(1) || sp_o == $past(sp_o) - SP_W'(1))); // R3

   AST_ACK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> (pc_load_o && $onehot0(ack_o))); // R4

   AST_GIE_LOW_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |-> !gie_o); // R5

   AST_RET_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && insn_last_i && insn_reti_i) |=> (busy_o && stk_re_o)); // R6

   AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> !busy_o); // R7

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pc_load_o) |=> busy_o); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(stk_we_o || stk_re_o || pc_load_o)); // R7

   AST_ONE_INSN: assert property (@(posedge clk) disable iff (!rst_n)
      wait_insn_q |-> !stk_we_o); // R8

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({stk_we_o, stk_re_o, pc_load_o}) <= 1); // R9

endmodule

bind intr_seq intr_seq_chk #(
   .NUM_REQ(NUM_REQ),
   .SP_W   (SP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .insn_last_i(insn_last_i),
   .insn_reti_i(insn_reti_i),
   .busy_o     (busy_o),
   .pc_load_o  (pc_load_o),
   .stk_we_o   (stk_we_o),
   .stk_re_o   (stk_re_o),
   .stk_addr_o (stk_addr_o),
   .sp_o       (sp_o),
   .gie_o      (gie_o),
   .ack_o      (ack_o)
);

// File: tb/intr_seq_test.sv
`timescale 1ns/1ps
module intr_seq_test;

   localparam int NREQ  = 8;
   localparam int PCW   = 14;
   localparam int SPW   = 16;
   localparam int VBASE = 2;
   localparam int SPI   = 'hF0;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NREQ-1:0] req_i = '0;
   logic            insn_last_i = 1'b0;
   logic            insn_reti_i = 1'b0;
   logic [PCW-1:0]  pc_next_i = '0;
   logic [7:0]      stk_rdata_i;
   logic            busy_o, pc_load_o, stk_we_o, stk_re_o, gie_o;
   logic [PCW-1:0]  pc_load_val_o;
   logic [SPW-1:0]  stk_addr_o, sp_o;
   logic [7:0]      stk_wdata_o;
   logic [NREQ-1:0] ack_o;

   logic [7:0] mem [256];

   int n_chk = 0;
   int n_bad = 0;

   logic [SPW-1:0] sp_m;
   logic           gie_m;
   logic [PCW-1:0] cur_pc;
   logic [PCW-1:0] saved_pc;

   always #2 clk = ~clk;

   intr_seq #(
      .NUM_REQ (NREQ),
      .PC_W    (PCW),
      .SP_W    (SPW),
      .VEC_BASE(VBASE),
      .SP_INIT (SPI),
      .GIE_INIT(1'b1)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .insn_last_i  (insn_last_i),
      .insn_reti_i  (insn_reti_i),
      .pc_next_i    (pc_next_i),
      .stk_rdata_i  (stk_rdata_i),
      .busy_o       (busy_o),
      .pc_load_o    (pc_load_o),
      .pc_load_val_o(pc_load_val_o),
      .stk_we_o     (stk_we_o),
      .stk_re_o     (stk_re_o),
      .stk_addr_o   (stk_addr_o),
      .stk_wdata_o  (stk_wdata_o),
      .sp_o         (sp_o),
      .gie_o        (gie_o),
      .ack_o        (ack_o)
   );

   // byte-wide stack memory with same-cycle read
   assign stk_rdata_i = mem[stk_addr_o[7:0]];
   always @(posedge clk) begin
      if (stk_we_o) mem[stk_addr_o[7:0]] <= stk_wdata_o;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int low_idx(input logic [NREQ-1:0] r);
      for (int i = 0; i < NREQ; i++) if (r[i]) return i;
      return 0;
   endfunction

   function automatic logic [PCW-1:0] exp_vec(input logic [NREQ-1:0] r);
      return PCW'(VBASE + 2 * low_idx(r));
   endfunction

   function automatic logic [NREQ-1:0] exp_ack(input logic [NREQ-1:0] r);
      return NREQ'(1) << low_idx(r);
   endfunction

   // entry sequence, entered at the negedge of cycle 1
   task automatic do_entry(input logic [NREQ-1:0] r, input logic [PCW-1:0] pcv, input bit noisy);
      logic [SPW-1:0] sp0;
      logic [7:0]     lo_b, hi_b;
      sp0  = sp_m;
      lo_b = pcv[7:0];
      hi_b = 8'(pcv >> 8);
      chk(busy_o && stk_we_o && !stk_re_o, "R3 low-byte write strobe", {stk_re_o, stk_we_o, busy_o}, 3'b011);
      chk(stk_addr_o == sp0, "R3 low-byte address", stk_addr_o, sp0);
      chk(stk_wdata_o == lo_b, "R3 low-byte data", stk_wdata_o, lo_b);
      chk(gie_o == 1'b0, "R5 enable cleared on entry", gie_o, 0);
      if (noisy) begin
         insn_last_i = 1'($urandom);
         req_i = r | NREQ'($urandom);
      end
      @(negedge clk);
      chk(stk_we_o && stk_addr_o == sp0 - 1, "R3 high-byte write address", stk_addr_o, sp0 - 1);
      chk(stk_wdata_o == hi_b, "R3 high-byte data", stk_wdata_o, hi_b);
      if (noisy) insn_last_i = 1'($urandom);
      @(negedge clk);
      chk(busy_o && !stk_we_o && !stk_re_o && !pc_load_o, "R7 gap cycle quiet and busy",
          {pc_load_o, stk_re_o, stk_we_o, busy_o}, 4'b0001);
      chk(sp_o == sp0 - 2, "R3 stack pointer down by two", sp_o, sp0 - 2);
      @(negedge clk);
      chk(pc_load_o && busy_o, "R4 load in fourth cycle", {busy_o, pc_load_o}, 2'b11);
      chk(pc_load_val_o == exp_vec(r), "R4 vector address", pc_load_val_o, exp_vec(r));
      chk(ack_o == exp_ack(r), "R4 one-hot acknowledge", ack_o, exp_ack(r));
      chk(mem[sp0[7:0]] == lo_b && mem[8'(sp0 - 1)] == hi_b, "R3 stacked bytes",
          {mem[8'(sp0 - 1)], mem[sp0[7:0]]}, {hi_b, lo_b});
      req_i       = r & ~exp_ack(r);
      insn_last_i = 1'b0;
      saved_pc    = pcv;
      sp_m        = sp0 - 2;
      gie_m       = 1'b0;
   endtask

   // return sequence, entered at the negedge of cycle 1
   task automatic do_return();
      logic [SPW-1:0] sp0;
      logic [15:0]    word;
      sp0  = sp_m;
      word = {mem[8'(sp0 + 1)], mem[8'(sp0 + 2)]};
      chk(busy_o && stk_re_o && !stk_we_o, "R6 first read strobe", {stk_we_o, stk_re_o, busy_o}, 3'b011);
      chk(stk_addr_o == sp0 + 1, "R6 high-byte read address", stk_addr_o, sp0 + 1);
      @(negedge clk);
      chk(stk_re_o && stk_addr_o == sp0 + 2, "R6 low-byte read address", stk_addr_o, sp0 + 2);
      @(negedge clk);
      chk(busy_o && !stk_re_o && !pc_load_o, "R7 return gap cycle", {pc_load_o, stk_re_o, busy_o}, 3'b001);
      @(negedge clk);
      chk(pc_load_o && pc_load_val_o == word[PCW-1:0], "R6 restored address", pc_load_val_o, word[PCW-1:0]);
      chk(pc_load_val_o == saved_pc, "R6 matches pushed address", pc_load_val_o, saved_pc);
      chk(gie_o == 1'b0 && ack_o == '0, "R6 enable still low, no acknowledge", {ack_o, gie_o}, 0);
      sp_m   = sp0 + 2;
      gie_m  = 1'b1;
   endtask

   // one main-program instruction of len cycles, then whatever it triggers
   task automatic run_insn(input int len, input bit reti, input logic [NREQ-1:0] r, input bit noisy);
      logic [PCW-1:0] pcv;
      pcv = cur_pc;
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         chk(busy_o == 1'b0, "R8 R7 idle during main instruction", busy_o, 0);
         if (c == 0) begin
            chk(sp_o == sp_m, "R3 R6 stack pointer between sequences", sp_o, sp_m);
            chk(gie_o == gie_m, "R5 R6 enable between sequences", gie_o, gie_m);
         end
         req_i       = r;
         insn_last_i = (c == len - 1);
         insn_reti_i = reti && (c == len - 1);
         pc_next_i   = pcv;
      end
      @(negedge clk);
      insn_last_i = 1'b0;
      insn_reti_i = 1'b0;
      if (reti) begin
         do_return();
      end else if (gie_m && (r != '0)) begin
         do_entry(r, pcv, noisy);
      end else begin
         chk(busy_o == 1'b0 && stk_we_o == 1'b0, "R2 no entry without enable or request",
             {stk_we_o, busy_o}, 0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !stk_we_o && !stk_re_o && !pc_load_o, "R1 strobes low in reset",
          {pc_load_o, stk_re_o, stk_we_o, busy_o}, 0);
      chk(sp_o == SPW'(SPI), "R1 stack pointer reset value", sp_o, SPI);
      chk(gie_o == 1'b1 && ack_o == '0, "R1 enable set, acknowledge clear", {ack_o, gie_o}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && sp_o == SPW'(SPI), "R1 idle after release", {sp_o, busy_o}, {SPW'(SPI), 1'b0});
      sp_m  = SPW'(SPI);
      gie_m = 1'b1;

      // R2 multi-cycle instruction finishes first, highest index alone
      cur_pc = 14'h2A5C;
      run_insn(4, 1'b0, 8'h80, 1'b0);
      // R2 enable low: pending requests are held off
      cur_pc = 14'h0101;
      run_insn(2, 1'b0, 8'hFF, 1'b0);
      // R6 return wins over pending requests, R8 one instruction before the next entry
      run_insn(1, 1'b1, 8'h06, 1'b0);
      cur_pc = 14'h3FFF;
      run_insn(3, 1'b0, 8'h06, 1'b1);
      // R4 all pending: lowest index wins; R7 noise inside sequences was injected above
      run_insn(1, 1'b1, 8'h00, 1'b0);
      cur_pc = 14'h00FF;
      run_insn(1, 1'b0, 8'hFF, 1'b1);
      run_insn(2, 1'b1, 8'hFF, 1'b0);
      cur_pc = 14'h1234;
      run_insn(1, 1'b0, 8'hF0, 1'b0);

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         int              len;
         logic [NREQ-1:0] r;
         bit              rt;
         len = 1 + int'($urandom % 4);
         if ($urandom % 3 == 0) r = '0;
         else                   r = NREQ'($urandom) & NREQ'($urandom);
         rt = !gie_m && ($urandom % 3 == 0);
         cur_pc = PCW'($urandom);
         run_insn(len, rt, r, 1'($urandom));
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule